// File: doc/BRIEF.md
# Dual-Host Semaphore Mailbox

This block lets two microcontrollers that share one register bus pass bytes to each other. It has three byte-wide mailbox registers that both hosts can read and write. A typical arrangement gives each host one mailbox for outgoing traffic and keeps the third mailbox for shared use. Every mailbox has a change flag. The flag goes up when a write alters the stored byte and goes down when someone reads that mailbox. By looking at these flags, a host can tell that fresh data has arrived and that the other host has picked up what it sent.

The flags appear in a read-only status byte, next to four condition bits. Two of them follow their inputs live: channel lock and motor overflow. Two are latched: header available and FIFO overflow. An enable byte masks the status byte onto one registered, active-low interrupt pin. Bit 1 of the third mailbox is tied to zero, so software can identify this revision of the block by reading it.

Top module: `mbx_top`

## Requirements
- R1: After the synchronous reset, all mailboxes, the enable byte and every latched flag are 0x00 or clear, and `irq_n` is 1.
- R2: Mailboxes sit at 0x08, 0x09 and 0x0A. A read returns the last byte written, except that bit 1 of the mailbox at 0x0A always reads 0. A mailbox keeps its value while it is not written.
- R3: A mailbox's change flag sets when a write alters its stored value, compared after bit 1 of 0x0A has been forced to 0. A write that leaves the value unchanged does not set the flag.
- R4: Reading a mailbox clears its own change flag. If a flag-setting write and a clearing read hit the same mailbox in the same cycle, the flag ends up set.
- R5: The status byte at 0x0B is laid out from bit 7 down as: flag of 0x08, flag of 0x09, flag of 0x0A, lock, header available, motor overflow, FIFO overflow, then 0. Writes to 0x0B have no effect.
- R6: The lock bit (bit 4) and the motor-overflow bit (bit 2) show `pll_lock` and `motor_ovf` as they are at the moment of the read. Neither is latched.
- R7: Bit 3 sets on an `hdr_new` pulse and clears on an `hdr_done` pulse. If both pulses come in the same cycle, the bit sets.
- R8: Bit 1 latches on an `fifo_ovf` pulse and clears when the status byte is read. A pulse that coincides with a status read leaves the bit set.
- R9: The enable byte at 0x0C is read/write. `irq_n` goes to 0 one cycle after any status bit and its matching enable bit are both 1, and otherwise returns to 1.
- R10: Reads of any other address return 0x00, and writes to them change nothing.
- R11: Read data is registered. It appears on `bus_rdata` in the cycle after the cycle in which `bus_re` is sampled, and reflects the state before any clear caused by that same read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pll_lock | input | 1 | Channel lock, live level |
| hdr_new | input | 1 | New header available pulse |
| hdr_done | input | 1 | Header read finished pulse |
| motor_ovf | input | 1 | Motor overflow, live level |
| fifo_ovf | input | 1 | FIFO overflow pulse |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest cases to reach are the collisions, where a flag is set and cleared in the same clock. For a mailbox, the bench raises write and read strobes together on one address. For the FIFO flag, it pulses the overflow input during a status read. It then reads the status byte again to confirm that the set took priority. The bench also checks the no-change write: it rewrites a stored value, including a write that differs only in the tied-off bit of the third mailbox, and confirms that no flag appears.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DW      = 8;
  localparam int MBX_AW      = 8;
  localparam int MBX_NUM     = 3;
  localparam int COND_W      = 4;
  localparam int COND_LSB    = 1;

  typedef struct packed {
    logic lock;
    logic hdr;
    logic motor;
    logic fifo;
  } cond_t;
endpackage

// File: rtl/mbx_sema_reg.sv
module mbx_sema_reg #(
  parameter int              DW        = 8,
  parameter logic [DW-1:0]   ZERO_MASK = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q,
  output logic          flag
);
  logic [DW-1:0] wmasked;
  logic          alters;

  assign wmasked = wdata & ~ZERO_MASK;
  assign alters  = wr_hit && (wmasked != q);

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      flag <= 1'b0;
    end else begin
      if (wr_hit) q <= wmasked;
      if (alters)      flag <= 1'b1;
      else if (rd_hit) flag <= 1'b0;
    end
  end

  AST_SEMA_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && (wmasked != q)) |=> flag); // R3
  AST_SEMA_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !wr_hit) |=> !flag); // R4
  AST_SEMA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(q)); // R2
  AST_SEMA_NOCHG: assert property (@(posedge clk) disable iff (rst)
    (!wr_hit && !rd_hit) |=> $stable(flag)); // R3
endmodule

// File: rtl/mbx_cond_status.sv
module mbx_cond_status
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pll_lock,
  input  logic  motor_ovf,
  input  logic  hdr_new,
  input  logic  hdr_done,
  input  logic  fifo_ovf,
  input  logic  stat_rd,
  output cond_t cond
);
  logic hdr_q;
  logic fifo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q  <= 1'b0;
      fifo_q <= 1'b0;
    end else begin
      if (hdr_new)       hdr_q <= 1'b1;
      else if (hdr_done) hdr_q <= 1'b0;
      if (fifo_ovf)      fifo_q <= 1'b1;
      else if (stat_rd)  fifo_q <= 1'b0;
    end
  end

  always_comb begin
    cond.lock  = pll_lock;
    cond.motor = motor_ovf;
    cond.hdr   = hdr_q;
    cond.fifo  = fifo_q;
  end

  AST_HDR_SET: assert property (@(posedge clk) disable iff (rst)
    hdr_new |=> cond.hdr); // R7
  AST_HDR_CLR: assert property (@(posedge clk) disable iff (rst)
    (hdr_done && !hdr_new) |=> !cond.hdr); // R7
  AST_FIFO_SET: assert property (@(posedge clk) disable iff (rst)
    fifo_ovf |=> cond.fifo); // R8
  AST_FIFO_CLR: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !fifo_ovf) |=> !cond.fifo); // R8
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ien_wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] stat_vec,
  output logic [DW-1:0] ien,
  output logic          irq_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ien   <= '0;
      irq_n <= 1'b1;
    end else begin
      if (ien_wr) ien <= wdata;
      irq_n <= ~|(stat_vec & ien);
    end
  end

  AST_IRQ_ASSERT: assert property (@(posedge clk) disable iff (rst)
    (|(stat_vec & ien)) |=> !irq_n); // R9
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (~|(stat_vec & ien)) |=> irq_n); // R9
  AST_IRQ_RST: assert property (@(posedge clk)
    rst |=> irq_n); // R1
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int             DW        = MBX_DW,
  parameter int             AW        = MBX_AW,
  parameter int             NUM_SEMA  = MBX_NUM,
  parameter logic [AW-1:0]  SEMA_BASE = 8'h08,
  parameter logic [DW-1:0]  VER_MASK  = 8'h02
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  input  logic          pll_lock,
  input  logic          hdr_new,
  input  logic          hdr_done,
  input  logic          motor_ovf,
  input  logic          fifo_ovf,
  output logic          irq_n
);
  localparam logic [AW-1:0] STAT_ADDR = SEMA_BASE + AW'(NUM_SEMA);
  localparam logic [AW-1:0] IEN_ADDR  = STAT_ADDR + AW'(1);

  logic [DW-1:0]       sema_q [NUM_SEMA];
  logic [NUM_SEMA-1:0] sema_flag;
  logic [NUM_SEMA-1:0] sema_wr;
  logic [NUM_SEMA-1:0] sema_rd;
  cond_t               cond;
  logic [DW-1:0]       stat_vec;
  logic [DW-1:0]       ien;
  logic [DW-1:0]       rd_mux;
  logic                stat_rd;
  logic                ien_wr;
  logic                mapped;

  assign stat_rd = bus_re && (bus_addr == STAT_ADDR);
  assign ien_wr  = bus_we && (bus_addr == IEN_ADDR);

  for (genvar g = 0; g < NUM_SEMA; g++) begin : g_sema
    localparam logic [AW-1:0] MY_ADDR = SEMA_BASE + AW'(g);
    localparam logic [DW-1:0] MY_MASK = (g == NUM_SEMA - 1) ? VER_MASK : '0;
    assign sema_wr[g] = bus_we && (bus_addr == MY_ADDR);
    assign sema_rd[g] = bus_re && (bus_addr == MY_ADDR);
    mbx_sema_reg #(.DW(DW), .ZERO_MASK(MY_MASK)) u_sema (
      .clk    (clk),
      .rst    (rst),
      .wr_hit (sema_wr[g]),
      .rd_hit (sema_rd[g]),
      .wdata  (bus_wdata),
      .q      (sema_q[g]),
      .flag   (sema_flag[g])
    );
  end

  mbx_cond_status u_cond (
    .clk       (clk),
    .rst       (rst),
    .pll_lock  (pll_lock),
    .motor_ovf (motor_ovf),
    .hdr_new   (hdr_new),
    .hdr_done  (hdr_done),
    .fifo_ovf  (fifo_ovf),
    .stat_rd   (stat_rd),
    .cond      (cond)
  );

  always_comb begin
    stat_vec = '0;
    for (int i = 0; i < NUM_SEMA; i++) stat_vec[DW-1-i] = sema_flag[i];
    stat_vec[COND_LSB +: COND_W] = cond;
  end

  mbx_irq #(.DW(DW)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .ien_wr   (ien_wr),
    .wdata    (bus_wdata),
    .stat_vec (stat_vec),
    .ien      (ien),
    .irq_n    (irq_n)
  );

  always_comb begin
    rd_mux = '0;
    mapped = 1'b0;
    for (int i = 0; i < NUM_SEMA; i++) begin
      if (sema_rd[i]) begin
        rd_mux = sema_q[i];
        mapped = 1'b1;
      end
    end
    if (bus_addr == STAT_ADDR) begin
      rd_mux = stat_vec;
      mapped = 1'b1;
    end
    if (bus_addr == IEN_ADDR) begin
      rd_mux = ien;
      mapped = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !mapped) |=> (bus_rdata == '0)); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata)); // R11
  AST_VER_BIT: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == SEMA_BASE + AW'(NUM_SEMA - 1)) |=> ((bus_rdata & VER_MASK) == '0)); // R2
endmodule

// File: tb/sim_mbx_top.sv
module sim_mbx_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       pll_lock = 1'b0;
  logic       hdr_new = 1'b0;
  logic       hdr_done = 1'b0;
  logic       motor_ovf = 1'b0;
  logic       fifo_ovf = 1'b0;
  logic       irq_n;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  mbx_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pll_lock(pll_lock), .hdr_new(hdr_new), .hdr_done(hdr_done),
    .motor_ovf(motor_ovf), .fifo_ovf(fifo_ovf), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset();
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    rd_chk("R1 sema0", 8'h08, 8'h00);
    rd_chk("R1 sema1", 8'h09, 8'h00);
    rd_chk("R1 sema2", 8'h0A, 8'h00);
    rd_chk("R1 status", 8'h0B, 8'h00);
    rd_chk("R1 enable", 8'h0C, 8'h00);
  endtask

  task automatic t_rw_flags();
    wr(8'h08, 8'hA5);
    wr(8'h09, 8'h3C);
    wr(8'h0A, 8'hFF);
    rd_chk("R5 R3 all flags", 8'h0B, 8'hE0);
    rd_chk("R2 sema0", 8'h08, 8'hA5);
    rd_chk("R4 flag0 cleared", 8'h0B, 8'h60);
    rd_chk("R2 sema1", 8'h09, 8'h3C);
    rd_chk("R2 sema2 ver bit", 8'h0A, 8'hFD);
    rd_chk("R4 all cleared", 8'h0B, 8'h00);
  endtask

  task automatic t_nochange();
    wr(8'h08, 8'hA5);
    wr(8'h0A, 8'hFF);
    rd_chk("R3 same-value writes", 8'h0B, 8'h00);
  endtask

  task automatic t_collide();
    bus_addr = 8'h08; bus_wdata = 8'h11; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    chk("R11 read before write", bus_rdata, 8'hA5);
    rd_chk("R4 set wins", 8'h0B, 8'h80);
    rd_chk("R2 collided value", 8'h08, 8'h11);
    rd_chk("R4 cleared after", 8'h0B, 8'h00);
  endtask

  task automatic t_live();
    pll_lock = 1'b1;
    rd_chk("R6 lock", 8'h0B, 8'h10);
    motor_ovf = 1'b1;
    rd_chk("R6 lock+motor", 8'h0B, 8'h14);
    pll_lock = 1'b0; motor_ovf = 1'b0;
    rd_chk("R6 released", 8'h0B, 8'h00);
  endtask

  task automatic t_header();
    hdr_new = 1'b1; @(negedge clk); hdr_new = 1'b0;
    rd_chk("R7 set", 8'h0B, 8'h08);
    rd_chk("R7 latched", 8'h0B, 8'h08);
    hdr_done = 1'b1; @(negedge clk); hdr_done = 1'b0;
    rd_chk("R7 cleared", 8'h0B, 8'h00);
    hdr_new = 1'b1; hdr_done = 1'b1; @(negedge clk);
    hdr_new = 1'b0; hdr_done = 1'b0;
    rd_chk("R7 set wins", 8'h0B, 8'h08);
    hdr_done = 1'b1; @(negedge clk); hdr_done = 1'b0;
  endtask

  task automatic t_fifo();
    fifo_ovf = 1'b1; @(negedge clk); fifo_ovf = 1'b0;
    rd_chk("R8 set", 8'h0B, 8'h02);
    rd_chk("R8 cleared by read", 8'h0B, 8'h00);
    fifo_ovf = 1'b1;
    rd_chk("R8 R11 read during pulse", 8'h0B, 8'h00);
    fifo_ovf = 1'b0;
    rd_chk("R8 set wins", 8'h0B, 8'h02);
    rd_chk("R8 cleared again", 8'h0B, 8'h00);
  endtask

  task automatic t_ignored();
    wr(8'h0B, 8'hFF);
    rd_chk("R5 status read-only", 8'h0B, 8'h00);
    wr(8'h20, 8'h55);
    wr(8'h07, 8'h55);
    rd_chk("R10 read 0x20", 8'h20, 8'h00);
    rd_chk("R10 read 0x07", 8'h07, 8'h00);
    rd_chk("R10 no flags", 8'h0B, 8'h00);
    rd_chk("R10 sema0 untouched", 8'h08, 8'h11);
    rd_chk("R10 enable untouched", 8'h0C, 8'h00);
  endtask

  task automatic t_irq();
    wr(8'h0C, 8'h80);
    rd_chk("R9 enable readback", 8'h0C, 8'h80);
    chk("R9 idle", {7'b0, irq_n}, 8'h01);
    wr(8'h09, 8'h77);
    @(negedge clk);
    chk("R9 masked flag", {7'b0, irq_n}, 8'h01);
    wr(8'h08, 8'h22);
    @(negedge clk);
    chk("R9 asserted", {7'b0, irq_n}, 8'h00);
    rd_chk("R9 sema0", 8'h08, 8'h22);
    @(negedge clk);
    chk("R9 released", {7'b0, irq_n}, 8'h01);
    wr(8'h0C, 8'h10);
    pll_lock = 1'b1;
    @(negedge clk);
    chk("R9 lock irq", {7'b0, irq_n}, 8'h00);
    pll_lock = 1'b0;
    @(negedge clk);
    chk("R9 lock drop", {7'b0, irq_n}, 8'h01);
    wr(8'h0C, 8'h00);
    rd_chk("R9 flag of 0x09 kept", 8'h0B, 8'h40);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rw_flags();
    t_nochange();
    t_collide();
    t_live();
    t_header();
    t_fifo();
    t_ignored();
    t_irq();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule